// File: doc/BRIEF.md
# Trap-Level Global Register Banking

This block holds the global integer registers of a processor core, banked by a 3-bit global level counter. Each global level selects its own bank of eight registers. Two combinational read ports and one synchronous write port address globals 0 to 7 of whichever bank the current level selects. The level moves in three ways. Software can write it directly. A trap-entry strobe saves the level into the outgoing trap-state word and steps to the next bank. A trap-return strobe reloads the level from a saved trap-state word.

The remaining trap-state fields come in on `tstate_in`. The block passes them through to `tstate_out`, with the saved level placed in bits 42:40. The processor-state word on `pstate_in` is filtered: its alternate, interrupt and MMU global-select bits are cleared, because bank choice here depends on the level alone. Trap-level stacking and hypervisor state are kept outside the block.

Top module: `glb_bank_top`

## Requirements
- R1: After synchronous reset, `gl_out` is 2, every global of every bank reads 0, and `tstate_out` is 0.
- R2: A software write (`gl_wr_en`) loads `gl_out` with bits 2:0 of `gl_wr_val` on the next edge and ignores all higher bits. Writing the value the level already has leaves every register unchanged.
- R3: Each of the 8 level values owns a separate bank of 8 globals. A write made while one level is active is not visible when another level is active.
- R4: On `trap_enter`, `tstate_out` becomes `tstate_in` with bits 42:40 replaced by the level held before the edge, and the level increments by one.
- R5: On `trap_enter` with the level already at MAXGL (default 7), the level stays at MAXGL.
- R6: On `trap_return` with `hv_en` high, the level becomes bits 42:40 of `saved_tstate`.
- R7: On `trap_return` with `hv_en` low, the level is unchanged.
- R8: Global 0 of every bank reads 0 on both read ports, and writes to index 0 are discarded.
- R9: If a register write and a level change fall in the same cycle, the write lands in the bank active before the change. A read in the following cycle returns data from the new bank.
- R10: `pstate_out` equals `pstate_in` with bits 11, 10 and 0 forced to 0. `pstate_in` has no effect on bank selection or on read data.
- R11: `trap_enter` and `trap_return` are never high together. Either strobe takes precedence over a software level write in the same cycle, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 64 | Read port A data, combinational |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 64 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Register write index |
| wr_data | input | 64 | Register write data |
| gl_wr_en | input | 1 | Software write of the level |
| gl_wr_val | input | 64 | Value for a software level write; only bits 2:0 are used |
| trap_enter | input | 1 | Trap-entry strobe |
| tstate_in | input | 64 | Other trap-state fields for the word saved on entry |
| trap_return | input | 1 | Done/retry return strobe |
| saved_tstate | input | 64 | Saved trap-state word used on return |
| hv_en | input | 1 | Hypervisor feature enable; gates the restore on return |
| pstate_in | input | 12 | Processor-state word |
| pstate_out | output | 12 | Processor-state word with the global-select bits cleared |
| gl_out | output | 3 | Current global level |
| tstate_out | output | 64 | Trap-state word captured at the last trap entry |

## Verification
On every cycle, the in-line assertions check how the level moves:
- the increment on trap entry and the saturation at MAXGL,
- the restore on return when `hv_en` is high and the hold when it is low,
- that the old level is saved into the trap-state field,
- that global 0 reads zero,
- that a write lands in the bank that was active at its edge,
- that the two trap strobes are never high together.

Some behaviours need the bench's reference model and its sequences:
- bank isolation across levels,
- the dropping of the upper bits of a software level write,
- a rewrite of the same level leaving the registers intact,
- a same-cycle write and level change, read back from both banks,
- the pass-through of the PSTATE filter.

// File: rtl/glb_pkg.sv
package glb_pkg;
    localparam int GL_W       = 3;
    localparam int NBANKS     = 1 << GL_W;
    localparam int TS_W       = 64;
    localparam int TS_GL_LSB  = 40;
    localparam int PS_W       = 12;
    localparam int PS_ALT_BIT = 0;
    localparam int PS_MMU_BIT = 10;
    localparam int PS_INT_BIT = 11;
    localparam logic [GL_W-1:0] GL_RESET = 3'd2;

    typedef logic [GL_W-1:0] gl_t;

    typedef enum logic [1:0] {
        GL_HOLD   = 2'd0,
        GL_SW     = 2'd1,
        GL_ENTER  = 2'd2,
        GL_RETURN = 2'd3
    } gl_op_e;

    typedef struct packed {
        gl_op_e op;
        gl_t    next;
    } gl_cmd_t;

    function automatic gl_t ts_gl_field(input logic [TS_W-1:0] ts);
        return ts[TS_GL_LSB +: GL_W];
    endfunction

    function automatic gl_t gl_step(input gl_t g, input gl_t limit);
        return (g >= limit) ? limit : gl_t'(g + 1'b1);
    endfunction

    function automatic logic [TS_W-1:0] ts_insert_gl(input logic [TS_W-1:0] ts, input gl_t g);
        logic [TS_W-1:0] r;
        r = ts;
        r[TS_GL_LSB +: GL_W] = g;
        return r;
    endfunction

    function automatic logic [PS_W-1:0] ps_clear_gsel(input logic [PS_W-1:0] p);
        logic [PS_W-1:0] r;
        r = p;
        r[PS_ALT_BIT] = 1'b0;
        r[PS_MMU_BIT] = 1'b0;
        r[PS_INT_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/glb_level_ctrl.sv
module glb_level_ctrl
    import glb_pkg::*;
#(
    parameter int MAXGL = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gl_wr_en,
    input  gl_t             gl_wr_val,
    input  logic            trap_enter,
    input  logic [TS_W-1:0] tstate_in,
    input  logic            trap_return,
    input  logic [TS_W-1:0] saved_tstate,
    input  logic            hv_en,
    output gl_t             gl_q,
    output logic [TS_W-1:0] tstate_q
);
    localparam gl_t GL_LIMIT = gl_t'(MAXGL);

    gl_cmd_t cmd;

    always_comb begin
        cmd.op   = GL_HOLD;
        cmd.next = gl_q;
        if (trap_enter) begin
            cmd.op   = GL_ENTER;
            cmd.next = gl_step(gl_q, GL_LIMIT);
        end else if (trap_return) begin
            cmd.op   = GL_RETURN;
            cmd.next = hv_en ? ts_gl_field(saved_tstate) : gl_q;
        end else if (gl_wr_en) begin
            cmd.op   = GL_SW;
            cmd.next = gl_wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gl_q     <= GL_RESET;
            tstate_q <= '0;
        end else begin
            gl_q <= cmd.next;
            if (cmd.op == GL_ENTER) begin
                tstate_q <= ts_insert_gl(tstate_in, gl_q);
            end
        end
    end

    AST_TRAP_SAVES_GL: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> ts_gl_field(tstate_q) == $past(gl_q)); // R4
    AST_TRAP_INCREMENTS: assert property (@(posedge clk) disable iff (rst)
        (trap_enter && gl_q < GL_LIMIT) |=> gl_q == gl_t'($past(gl_q) + 1'b1)); // R4
    AST_TRAP_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (trap_enter && gl_q == GL_LIMIT) |=> gl_q == GL_LIMIT); // R5
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (trap_return && hv_en) |=> gl_q == $past(ts_gl_field(saved_tstate))); // R6
    AST_RETURN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (trap_return && !hv_en) |=> $stable(gl_q)); // R7
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(trap_enter && trap_return)); // R11
endmodule

// File: rtl/glb_bank_file.sv
module glb_bank_file
    import glb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NREGS  = 8,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  gl_t                        bank_sel,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NBANKS][NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANKS; b++) begin
                for (int r = 0; r < NREGS; r++) begin
                    mem[b][r] <= '0;
                end
            end
        end else if (wr_en && wr_idx != '0) begin
            mem[bank_sel][wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0) begin
                rd_data[p] = '0;
            end else begin
                rd_data[p] = mem[bank_sel][rd_idx[p]];
            end
        end

        AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
            rd_idx[p] == '0 |-> rd_data[p] == '0); // R8
    end

    AST_WRITE_OLD_BANK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=> mem[$past(bank_sel)][$past(wr_idx)] == $past(wr_data)); // R9
endmodule

// File: rtl/glb_ps_filter.sv
module glb_ps_filter
    import glb_pkg::*;
(
    input  logic [PS_W-1:0] ps_in,
    output logic [PS_W-1:0] ps_out
);
    always_comb begin
        ps_out = ps_clear_gsel(ps_in);
    end
endmodule

// File: rtl/glb_bank_top.sv
module glb_bank_top
    import glb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NREGS  = 8,
    parameter int MAXGL  = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]        rd_a_data,
    input  logic [$clog2(NREGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]        rd_b_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     gl_wr_en,
    input  logic [TS_W-1:0]          gl_wr_val,
    input  logic                     trap_enter,
    input  logic [TS_W-1:0]          tstate_in,
    input  logic                     trap_return,
    input  logic [TS_W-1:0]          saved_tstate,
    input  logic                     hv_en,
    input  logic [PS_W-1:0]          pstate_in,
    output logic [PS_W-1:0]          pstate_out,
    output logic [GL_W-1:0]          gl_out,
    output logic [TS_W-1:0]          tstate_out
);
    localparam int IDX_W = $clog2(NREGS);
    localparam int NRD   = 2;

    gl_t                        gl_cur;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx_v;
    logic [NRD-1:0][DATA_W-1:0] rd_data_v;

    glb_level_ctrl #(.MAXGL(MAXGL)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .gl_wr_en     (gl_wr_en),
        .gl_wr_val    (gl_wr_val[GL_W-1:0]),
        .trap_enter   (trap_enter),
        .tstate_in    (tstate_in),
        .trap_return  (trap_return),
        .saved_tstate (saved_tstate),
        .hv_en        (hv_en),
        .gl_q         (gl_cur),
        .tstate_q     (tstate_out)
    );

    assign rd_idx_v[0] = rd_a_idx;
    assign rd_idx_v[1] = rd_b_idx;
    assign rd_a_data   = rd_data_v[0];
    assign rd_b_data   = rd_data_v[1];

    glb_bank_file #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(NRD)) u_file (
        .clk      (clk),
        .rst      (rst),
        .bank_sel (gl_cur),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx_v),
        .rd_data  (rd_data_v)
    );

    glb_ps_filter u_ps (
        .ps_in  (pstate_in),
        .ps_out (pstate_out)
    );

    assign gl_out = gl_cur;
endmodule

// File: tb/sim_glb_bank_top.sv
module sim_glb_bank_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, gl_wr_en = 1'b0, trap_enter = 1'b0, trap_return = 1'b0, hv_en = 1'b0;
    logic [63:0] gl_wr_val = '0, tstate_in = '0, saved_tstate = '0, tstate_out;
    logic [11:0] pstate_in = '0, pstate_out;
    logic [2:0]  gl_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] mdl [8][8];
    logic [2:0]  mgl;
    logic [63:0] mts;

    always #10 clk = ~clk;

    glb_bank_top u0 (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .gl_wr_en(gl_wr_en), .gl_wr_val(gl_wr_val),
        .trap_enter(trap_enter), .tstate_in(tstate_in),
        .trap_return(trap_return), .saved_tstate(saved_tstate), .hv_en(hv_en),
        .pstate_in(pstate_in), .pstate_out(pstate_out),
        .gl_out(gl_out), .tstate_out(tstate_out)
    );

    function automatic logic [63:0] exp_rd(input logic [2:0] idx);
        return (idx == 3'd0) ? 64'd0 : mdl[mgl][idx];
    endfunction

    function automatic logic [11:0] exp_ps(input logic [11:0] p);
        return p & ~12'hC01;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reads(input string tag);
        chk(tag, rd_a_data, exp_rd(rd_a_idx));
        chk(tag, rd_b_data, exp_rd(rd_b_idx));
    endtask

    // Called just after a negedge with inputs set; clocks once and updates the model.
    task automatic tick(input string gl_tag, input string rd_tag);
        #1;
        chk_reads(rd_tag);
        chk("R10", {52'd0, pstate_out}, {52'd0, exp_ps(pstate_in)});
        @(posedge clk);
        #1;
        if (wr_en && wr_idx != 3'd0) mdl[mgl][wr_idx] = wr_data;
        if (trap_enter) begin
            mts = tstate_in;
            mts[42:40] = mgl;
            mgl = (mgl == 3'd7) ? 3'd7 : mgl + 3'd1;
        end else if (trap_return) begin
            if (hv_en) mgl = saved_tstate[42:40];
        end else if (gl_wr_en) begin
            mgl = gl_wr_val[2:0];
        end
        chk(gl_tag, {61'd0, gl_out}, {61'd0, mgl});
        chk(gl_tag, tstate_out, mts);
        @(negedge clk);
        wr_en = 1'b0; gl_wr_en = 1'b0; trap_enter = 1'b0; trap_return = 1'b0;
    endtask

    task automatic set_gl(input logic [2:0] g, input string tag);
        gl_wr_en = 1'b1;
        gl_wr_val = {$urandom(), $urandom()};
        gl_wr_val[2:0] = g;
        tick(tag, "R3");
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 8; b++) for (int r = 0; r < 8; r++) mdl[b][r] = '0;
        mgl = 3'd2;
        mts = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", {61'd0, gl_out}, 64'd2);
        chk("R1", tstate_out, 64'd0);
        for (int i = 0; i < 8; i++) begin
            rd_a_idx = i[2:0]; rd_b_idx = 3'(7 - i);
            #1;
            chk("R1", rd_a_data, 64'd0);
            chk("R1", rd_b_data, 64'd0);
        end
        @(negedge clk);

        // R8 write to index 0 is discarded
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 64'hDEAD_BEEF_0000_0001;
        tick("R8", "R8");
        rd_a_idx = 3'd0; rd_b_idx = 3'd0;
        #1;
        chk("R8", rd_a_data, 64'd0);
        chk("R8", rd_b_data, 64'd0);

        // R2 upper bits ignored
        gl_wr_en = 1'b1; gl_wr_val = 64'hFFFF_FFFF_FFFF_FFF9;
        tick("R2", "R3");
        chk("R2", {61'd0, gl_out}, 64'd1);

        // R2 same-value write keeps contents
        wr_en = 1'b1; wr_idx = 3'd4; wr_data = 64'h1111_2222_3333_4444;
        tick("R3", "R3");
        set_gl(3'd1, "R2");
        rd_a_idx = 3'd4;
        #1;
        chk("R2", rd_a_data, 64'h1111_2222_3333_4444);

        // R9 same-cycle write and level change
        wr_en = 1'b1; wr_idx = 3'd5; wr_data = 64'hAAAA_5555_AAAA_5555;
        gl_wr_en = 1'b1; gl_wr_val = 64'd6;
        tick("R9", "R3");
        rd_a_idx = 3'd5;
        #1;
        chk("R9", rd_a_data, 64'd0);
        set_gl(3'd1, "R9");
        rd_a_idx = 3'd5;
        #1;
        chk("R9", rd_a_data, 64'hAAAA_5555_AAAA_5555);

        // R3 another bank does not see bank 1 data
        set_gl(3'd3, "R3");
        rd_a_idx = 3'd4; rd_b_idx = 3'd5;
        #1;
        chk("R3", rd_a_data, 64'd0);
        chk("R3", rd_b_data, 64'd0);

        // R4 / R5 trap entry and saturation
        set_gl(3'd6, "R2");
        tstate_in = 64'h0123_4567_89AB_CDEF;
        trap_enter = 1'b1; tick("R4", "R3");
        chk("R4", {61'd0, tstate_out[42:40]}, 64'd6);
        trap_enter = 1'b1; tick("R5", "R3");
        chk("R5", {61'd0, gl_out}, 64'd7);
        trap_enter = 1'b1; tick("R5", "R3");
        chk("R5", {61'd0, gl_out}, 64'd7);
        chk("R5", {61'd0, tstate_out[42:40]}, 64'd7);

        // R7 return without hypervisor leaves level alone; R11 strobe beats sw write
        hv_en = 1'b0; saved_tstate = 64'h0000_0300_0000_0000;
        trap_return = 1'b1; gl_wr_en = 1'b1; gl_wr_val = 64'd4;
        tick("R7", "R3");
        chk("R11", {61'd0, gl_out}, 64'd7);

        // R6 return with hypervisor restores level
        hv_en = 1'b1;
        trap_return = 1'b1;
        tick("R6", "R3");
        chk("R6", {61'd0, gl_out}, 64'd3);

        // R10 pstate filter independent of banks
        pstate_in = 12'hFFF;
        rd_a_idx = 3'd4;
        #1;
        chk("R10", {52'd0, pstate_out}, 64'h3FE);
        chk("R10", rd_a_data, exp_rd(3'd4));

        // Constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int sel;
            string tag;
            sel = $urandom_range(0, 99);
            rd_a_idx = 3'($urandom()); rd_b_idx = 3'($urandom());
            pstate_in = 12'($urandom());
            wr_en = ($urandom_range(0, 1) == 1);
            wr_idx = 3'($urandom());
            wr_data = {$urandom(), $urandom()};
            hv_en = ($urandom_range(0, 3) != 0);
            tstate_in = {$urandom(), $urandom()};
            saved_tstate = {$urandom(), $urandom()};
            gl_wr_val = {$urandom(), $urandom()};
            tag = "R3";
            if (sel < 15) begin
                trap_enter = 1'b1; tag = "R4";
            end else if (sel < 30) begin
                trap_return = 1'b1; tag = hv_en ? "R6" : "R7";
            end else if (sel < 50) begin
                gl_wr_en = 1'b1; tag = "R2";
            end
            if (sel >= 5 && sel < 10) gl_wr_en = 1'b1;
            tick(tag, "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule